// File: doc/BRIEF.md
# Bit Test and Modify Unit

This block picks one bit of a 16-bit or 32-bit operand, reports that bit's value on a carry output, and can optionally write the bit back as set, cleared or inverted. An execution pipeline uses it to carry out bit-test style operations on a register operand. The result comes back one clock later, together with a strobe that tells the register file whether to write it back.

The bit position comes from an offset input that is wider than needed. The offset wraps by the size of the operand, so an offset beyond the operand width selects a bit inside the operand. In 16-bit mode only the low half of the word takes part. The upper half of the result is the upper half of the input.

Top module: `bit_test_unit`

## Requirements
- R1: For every accepted request, `out_carry` is the value the selected bit had in `in_data` before any change.
- R2: Operation code 2'b00 (test) returns `in_data` unchanged on `out_data`.
- R3: Operation code 2'b01 (set) returns `in_data` with the selected bit forced to 1.
- R4: Operation code 2'b10 (clear) returns `in_data` with the selected bit forced to 0.
- R5: Operation code 2'b11 (complement) returns `in_data` with the selected bit inverted.
- R6: The selected bit index is `in_offset` modulo 32 when `in_wide` is 1, and `in_offset` modulo 16 when `in_wide` is 0. Bit index 0 is the least significant bit.
- R7: When `in_wide` is 0, bits 31:16 of `out_data` equal bits 31:16 of `in_data` for every operation.
- R8: `out_wb_en` is 1 only in a cycle where `out_valid` is 1 and the operation was set, clear or complement. It is never 1 for test.
- R9: `out_valid` equals `in_valid` delayed by exactly one clock.
- R10: While `rst` is high at a clock edge, all outputs become 0.
- R11: A cycle with `in_valid` at 0 leaves `out_data` and `out_carry` at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation: 00 test, 01 set, 10 clear, 11 complement |
| in_wide | input | 1 | 1 selects a 32-bit operand, 0 selects a 16-bit operand |
| in_data | input | 32 | Operand |
| in_offset | input | 8 | Bit offset, wrapped by the operand size |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | 32 | Operand after the operation |
| out_carry | output | 1 | Original value of the selected bit |
| out_wb_en | output | 1 | Write-back enable for the result |

## Verification
The bench drives offsets at and just past each wrap point: 15, 16, 31, 32 and 255, in both sizes. A design that wrapped by the wrong width, or did not wrap at all, would change a bit in the upper half during 16-bit mode, or would report the wrong carry. It sets bits that are already set and clears bits that are already clear. This catches a design that takes the carry from the result instead of the input, because the carry must still show the old value. It also puts idle cycles between requests and sends requests back to back. A result register that loads without looking at the strobe would then lose data, and a write-back enable not gated by the operation would fire on a test.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    BT_TEST  = 2'b00,
    BT_SET   = 2'b01,
    BT_CLEAR = 2'b10,
    BT_FLIP  = 2'b11
  } bt_op_e;

endpackage

// File: rtl/bt_index_wrap.sv
module bt_index_wrap #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int OFF_W    = 8,
  localparam int SEL_W   = $clog2(DATA_W)
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic              wide,
  output logic [SEL_W-1:0]  index,
  output logic [DATA_W-1:0] mask
);

  logic [OFF_W-1:0] wide_mod;
  logic [OFF_W-1:0] narrow_mod;

  always_comb begin
    wide_mod   = offset % OFF_W'(DATA_W);
    narrow_mod = offset % OFF_W'(NARROW_W);
    index      = wide ? SEL_W'(wide_mod) : SEL_W'(narrow_mod);
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (index == SEL_W'(i));
  end

endmodule

// File: rtl/bt_bit_alter.sv
module bt_bit_alter
  import bt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] mask,
  input  bt_op_e            op,
  output logic [DATA_W-1:0] result,
  output logic              old_bit,
  output logic              writes
);

  assign old_bit = |(data & mask);
  assign writes  = (op != BT_TEST);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      unique case (op)
        BT_SET:   result[i] = data[i] | mask[i];
        BT_CLEAR: result[i] = data[i] & ~mask[i];
        BT_FLIP:  result[i] = data[i] ^ mask[i];
        default:  result[i] = data[i];
      endcase
    end
  end

endmodule

// File: rtl/bt_result_reg.sv
module bt_result_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [DATA_W-1:0] result,
  input  logic              old_bit,
  input  logic              writes,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic              q_carry,
  output logic              q_wb
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_carry <= 1'b0;
      q_wb    <= 1'b0;
    end else begin
      q_valid <= valid;
      q_wb    <= valid & writes;
      if (valid) begin
        q_data  <= result;
        q_carry <= old_bit;
      end
    end
  end

endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
  import bt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int OFF_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic              in_wide,
  input  logic [DATA_W-1:0] in_data,
  input  logic [OFF_W-1:0]  in_offset,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_carry,
  output logic              out_wb_en
);

  localparam int SEL_W = $clog2(DATA_W);

  logic [SEL_W-1:0]  sel_index;
  logic [DATA_W-1:0] sel_mask;
  logic [DATA_W-1:0] new_data;
  logic              orig_bit;
  logic              is_write;
  bt_op_e            op_q;

  assign op_q = bt_op_e'(in_op);

  bt_index_wrap #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .OFF_W(OFF_W)
  ) u_wrap (
    .offset(in_offset), .wide(in_wide), .index(sel_index), .mask(sel_mask)
  );

  bt_bit_alter #(.DATA_W(DATA_W)) u_alter (
    .data(in_data), .mask(sel_mask), .op(op_q),
    .result(new_data), .old_bit(orig_bit), .writes(is_write)
  );

  bt_result_reg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst(rst), .valid(in_valid), .result(new_data),
    .old_bit(orig_bit), .writes(is_write),
    .q_valid(out_valid), .q_data(out_data), .q_carry(out_carry), .q_wb(out_wb_en)
  );

  // R9: valid strobe is delayed by exactly one clock
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8: write-back only with a valid, modifying operation
  assert_wb_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    out_wb_en |-> out_valid);
  assert_no_wb_on_test_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b00) |=> !out_wb_en);

  // R2: test returns the operand unchanged
  assert_test_keeps_data_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b00) |=> out_data == $past(in_data));

  // R3/R4/R5: at most one bit differs from the operand
  assert_single_bit_change_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> $countones(out_data ^ $past(in_data)) <= 1);

  // R7: narrow mode leaves the upper bits untouched
  assert_upper_untouched_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_wide) |=> out_data[DATA_W-1:NARROW_W] == $past(in_data[DATA_W-1:NARROW_W]));

  // R11: idle cycles hold result and carry
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_carry)));

endmodule

// File: tb/tb_bit_test_unit.sv
`timescale 1ns/1ps
module tb_bit_test_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic        in_wide = 1'b1;
  logic [31:0] in_data = '0;
  logic [7:0]  in_offset = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_carry;
  logic        out_wb_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] m_data = '0;
  logic        m_carry = 1'b0;
  logic        m_valid = 1'b0;
  logic        m_wb = 1'b0;

  always #2.5 clk = ~clk;

  bit_test_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_wide(in_wide),
    .in_data(in_data), .in_offset(in_offset), .out_valid(out_valid),
    .out_data(out_data), .out_carry(out_carry), .out_wb_en(out_wb_en)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Reference model of one request, evaluated from the requirements
  task automatic step(bit v, logic [1:0] op, bit wide, logic [31:0] d, logic [7:0] off);
    int idx;
    logic [31:0] nd;
    string tag;
    in_valid = v; in_op = op; in_wide = wide; in_data = d; in_offset = off;
    idx = wide ? (int'(off) % 32) : (int'(off) % 16);
    nd = d;
    case (op)
      2'b01: nd[idx] = 1'b1;
      2'b10: nd[idx] = 1'b0;
      2'b11: nd[idx] = ~d[idx];
      default: nd = d;
    endcase
    m_valid = v;
    m_wb = v && (op != 2'b00);
    if (v) begin
      m_data = nd;
      m_carry = d[idx];
    end
    @(negedge clk);
    chk("R9 valid", 32'(out_valid), 32'(m_valid));
    chk("R8 wb_en", 32'(out_wb_en), 32'(m_wb));
    if (!v) tag = "R11 hold";
    else case (op)
      2'b00: tag = "R2 test";
      2'b01: tag = "R3 set";
      2'b10: tag = "R4 clear";
      default: tag = "R5 complement";
    endcase
    if (v && off >= (wide ? 8'd32 : 8'd16)) tag = {tag, " R6 wrap"};
    chk(tag, out_data, m_data);
    chk(v ? "R1 carry" : "R11 carry hold", 32'(out_carry), 32'(m_carry));
    if (v && !wide) chk("R7 upper", {16'h0, out_data[31:16]}, {16'h0, d[31:16]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 valid", 32'(out_valid), 0);
    chk("R10 data", out_data, 0);
    chk("R10 carry", 32'(out_carry), 0);
    chk("R10 wb", 32'(out_wb_en), 0);
    rst = 1'b0;
    step(1, 2'b00, 1, 32'hA5A5_0F0F, 8'd0);
    step(1, 2'b00, 1, 32'h8000_0000, 8'd31);
    step(1, 2'b01, 1, 32'h0000_0000, 8'd7);
    step(1, 2'b01, 1, 32'hFFFF_FFFF, 8'd3);   // already set
    step(1, 2'b10, 1, 32'hFFFF_FFFF, 8'd31);
    step(1, 2'b10, 1, 32'h0000_0000, 8'd12);  // already clear
    step(1, 2'b11, 1, 32'h1234_5678, 8'd4);
    step(1, 2'b11, 1, 32'h1234_5678, 8'd32);  // R6 wraps to 0
    step(1, 2'b01, 1, 32'h0, 8'd37);          // R6 wraps to 5
    step(1, 2'b10, 1, 32'hFFFF_FFFF, 8'd255); // R6 wraps to 31
    step(0, 2'b11, 1, 32'hDEAD_BEEF, 8'd1);   // R11 idle
    step(0, 2'b01, 0, 32'h0, 8'd2);
    step(1, 2'b01, 0, 32'hABCD_0000, 8'd15);
    step(1, 2'b01, 0, 32'hABCD_0000, 8'd16);  // R6 narrow wraps to 0
    step(1, 2'b11, 0, 32'hFFFF_FFFF, 8'd31);  // R7 upper untouched
    step(1, 2'b10, 0, 32'h5555_FFFF, 8'd20);
    step(1, 2'b00, 0, 32'h0001_8000, 8'd255);
    for (int n = 0; n < 400; n++)
      step($urandom_range(0, 3) != 0, 2'($urandom), 1'($urandom), $urandom, 8'($urandom));
    rst = 1'b1;
    @(negedge clk);
    chk("R10 valid after reset", 32'(out_valid), 0);
    chk("R10 data after reset", out_data, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule